// File: doc/BRIEF.md
# Asynchronous Serial Frame Transmitter

This block turns one parallel data word into an asynchronous NRZ frame on a single output line. A frame is a low start bit, a data field of 5 to 9 bits sent in either bit order, an optional even or odd parity bit, and a high stop period of half a bit up to two bits. Bit timing comes from an external enable pulse that runs at sixteen times the bit rate, so one bit lasts 16 pulses. The block does not divide any clock itself.

Software or an upstream block hands a word over through a one-deep holding register with a valid/ready handshake. A word that arrives while a frame is being sent waits in that register. It starts on the very pulse that ends the current stop period, so the line carries no idle gap between the two frames. An optional clear-to-send input can hold back the start of a new frame, but it never cuts off a frame that has already begun. Two flags report progress: one shows that the holding register is empty, the other shows that the line has fallen idle after a frame. The frame settings are inputs. They are captured when a frame starts, and they stay fixed for the rest of that frame.

Top module: `uart_frame_tx`

## Requirements
- R1: After reset, tx_o is 1, tx_empty_o is 1, tx_done_o is 1 and ready_o is 1. tx_o stays 1 whenever no frame is being sent.
- R2: A frame starts only on a cycle with tick_i high. Its start bit holds tx_o at 0 for exactly 16 tick_i pulses, counting the pulse that starts the frame.
- R3: data_bits_i gives the data field length as a count from 5 to 9. Only the low data_bits_i bits of the word are sent, each for 16 ticks.
- R4: When msb_first_i is 0, the data field is sent from bit 0 upward. When it is 1, it is sent from bit data_bits_i-1 downward. For example, 0x50 with 7 bits, sent from bit 0, goes out as 0,0,0,0,1,0,1.
- R5: parity_i encodes the parity mode: 2'b01 is even, 2'b10 is odd, and 2'b00 or 2'b11 means no parity bit. The parity bit lasts 16 ticks and makes the count of ones in the data plus parity even (even mode) or odd (odd mode).
- R6: stop_sel_i sets the stop period at logic 1: 2'b00 is 8 ticks, 2'b01 is 16, 2'b10 is 24 and 2'b11 is 32.
- R7: A word that is pending when the stop period ends begins its start bit on the tick that ends that stop period, with no idle tick in between.
- R8: ready_o equals tx_empty_o. Both fall when a word is accepted (valid_i and ready_o high at a clock edge). Both rise on the edge where that word moves into the shift stage, and they stay low until then.
- R9: tx_done_o is 0 from the edge that starts a frame until the tick that ends the stop period. It rises on that tick if no new frame starts there.
- R10: When cts_en_i is 1 and cts_i is 1, no new frame starts and a pending word stays pending. A frame already under way runs to its end. When cts_en_i is 0, cts_i has no effect.
- R11: data_bits_i, msb_first_i, parity_i and stop_sel_i are captured at the start of a frame. Changing them during a frame does not change that frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| tick_i | input | 1 | Enable pulse at 16 times the bit rate |
| data_i | input | 9 | Word to send, right-aligned |
| valid_i | input | 1 | data_i is offered |
| ready_o | output | 1 | Holding register can take a word |
| data_bits_i | input | 4 | Data field length, 5 to 9 |
| msb_first_i | input | 1 | 1 sends the top data bit first |
| parity_i | input | 2 | Parity mode (01 even, 10 odd, else none) |
| stop_sel_i | input | 2 | Stop period selector |
| cts_en_i | input | 1 | Enables gating by cts_i |
| cts_i | input | 1 | 1 blocks the start of a new frame |
| tx_o | output | 1 | Serial line |
| tx_empty_o | output | 1 | Holding register empty |
| tx_done_o | output | 1 | Line idle after the last frame |

## Verification
The hardest case to reach is a clear-to-send change that lands in the middle of a frame while a second word is already waiting. The frame under way must still finish, and the waiting word must not start. To get there, the bench writes a second word as soon as the first moves into the shift stage. Once the first frame is well into its data field, the bench raises cts_i. It then records the line, the done flag and the empty flag on every tick, and checks that the line stays high and the word stays pending after the stop period. The back-to-back case comes from the same recording. The bench chains three writes, each issued the moment ready_o rises, so each frame's start index must equal the previous frame's end index exactly.

// File: rtl/uart_tx_pkg.sv
package uart_tx_pkg;
  typedef enum logic [2:0] {
    ST_IDLE, ST_START, ST_DATA, ST_PAR, ST_STOP
  } tx_state_e;

  localparam logic [1:0] PAR_EVEN = 2'b01;
  localparam logic [1:0] PAR_ODD  = 2'b10;
endpackage

// File: rtl/uart_tx_hold.sv
module uart_tx_hold #(
  parameter int unsigned DW = 9
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          valid_i,
  input  logic [DW-1:0] data_i,
  input  logic          take_i,
  output logic          ready_o,
  output logic          pend_o,
  output logic [DW-1:0] word_o
);
  logic          full_q;
  logic [DW-1:0] data_q;

  assign ready_o = !full_q;
  assign pend_o  = full_q;
  assign word_o  = data_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      full_q <= 1'b0;
      data_q <= '0;
    end else if (take_i) begin
      full_q <= 1'b0;
    end else if (valid_i && !full_q) begin
      full_q <= 1'b1;
      data_q <= data_i;
    end
  end

  // R8
  hold_keep_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (full_q && !take_i) |=> (full_q && $stable(data_q)));
  // R8
  no_empty_take_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    take_i |-> full_q);
endmodule

// File: rtl/uart_tx_shift.sv
module uart_tx_shift
  import uart_tx_pkg::*;
#(
  parameter int unsigned DW     = 9,
  parameter int unsigned MIN_DW = 5,
  parameter int unsigned OSR    = 16,
  parameter int unsigned NW     = $clog2(DW + 1)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          tick_i,
  input  logic          pend_i,
  input  logic          start_ok_i,
  input  logic [DW-1:0] word_i,
  input  logic [NW-1:0] len_i,
  input  logic          msb_first_i,
  input  logic [1:0]    par_mode_i,
  input  logic [1:0]    stop_sel_i,
  output logic          load_o,
  output logic          tx_o,
  output logic          done_o
);
  localparam int unsigned CW = $clog2(2 * OSR);
  localparam int unsigned SW = CW + 1;

  tx_state_e     state_q;
  logic [CW-1:0] cnt_q;
  logic [SW-1:0] stop_len_q;
  logic [DW-1:0] sh_q;
  logic [NW-1:0] nbits_q, idx_q;
  logic          par_en_q, par_q, tx_q, done_q;

  logic [NW-1:0] len_c;
  logic [DW-1:0] ord_c, mask_c;
  logic          par_c;
  logic [SW-1:0] stop_c;
  logic          bit_last, can_start;

  always_comb begin
    if (len_i < NW'(MIN_DW))  len_c = NW'(MIN_DW);
    else if (len_i > NW'(DW)) len_c = NW'(DW);
    else                      len_c = len_i;
  end

  // Data field is reordered at load so the shifter always sends bit 0 next.
  always_comb begin
    ord_c  = '0;
    mask_c = '0;
    for (int i = 0; i < DW; i++) begin
      if (NW'(i) < len_c) begin
        mask_c[i] = 1'b1;
        ord_c[i]  = msb_first_i ? word_i[len_c - NW'(1) - NW'(i)] : word_i[i];
      end
    end
  end

  assign par_c  = (^(word_i & mask_c)) ^ (par_mode_i == PAR_ODD);
  assign stop_c = SW'((OSR / 2) * (int'(stop_sel_i) + 1));

  always_comb begin
    unique case (state_q)
      ST_START, ST_DATA, ST_PAR: bit_last = (cnt_q == CW'(OSR - 1));
      ST_STOP:                   bit_last = (SW'(cnt_q) == stop_len_q - SW'(1));
      default:                   bit_last = 1'b0;
    endcase
  end

  assign can_start = tick_i && pend_i && start_ok_i &&
                     ((state_q == ST_IDLE) || (state_q == ST_STOP && bit_last));
  assign load_o = can_start;
  assign tx_o   = tx_q;
  assign done_o = done_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q    <= ST_IDLE;
      cnt_q      <= '0;
      stop_len_q <= '0;
      sh_q       <= '0;
      nbits_q    <= '0;
      idx_q      <= '0;
      par_en_q   <= 1'b0;
      par_q      <= 1'b0;
      tx_q       <= 1'b1;
      done_q     <= 1'b1;
    end else if (can_start) begin
      state_q    <= ST_START;
      cnt_q      <= '0;
      stop_len_q <= stop_c;
      sh_q       <= ord_c;
      nbits_q    <= len_c;
      idx_q      <= '0;
      par_en_q   <= (par_mode_i == PAR_EVEN) || (par_mode_i == PAR_ODD);
      par_q      <= par_c;
      tx_q       <= 1'b0;
      done_q     <= 1'b0;
    end else if (tick_i && state_q != ST_IDLE) begin
      if (!bit_last) begin
        cnt_q <= cnt_q + CW'(1);
      end else begin
        cnt_q <= '0;
        unique case (state_q)
          ST_START: begin
            state_q <= ST_DATA;
            tx_q    <= sh_q[0];
          end
          ST_DATA: begin
            if (idx_q == nbits_q - NW'(1)) begin
              state_q <= par_en_q ? ST_PAR : ST_STOP;
              tx_q    <= par_en_q ? par_q : 1'b1;
            end else begin
              sh_q  <= sh_q >> 1;
              idx_q <= idx_q + NW'(1);
              tx_q  <= sh_q[1];
            end
          end
          ST_PAR: begin
            state_q <= ST_STOP;
            tx_q    <= 1'b1;
          end
          default: begin
            state_q <= ST_IDLE;
            done_q  <= 1'b1;
          end
        endcase
      end
    end
  end

  // R2
  start_on_tick_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(state_q == ST_START) |-> $past(tick_i));
  // R1
  idle_high_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_IDLE) |-> tx_o);
  // R6
  stop_len_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_STOP) |-> (SW'(cnt_q) < stop_len_q));
  // R9
  done_low_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q != ST_IDLE) |-> !done_o);
  // R10
  cts_block_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_IDLE && !start_ok_i) |=> (state_q == ST_IDLE));
endmodule

// File: rtl/uart_frame_tx.sv
module uart_frame_tx #(
  parameter int unsigned DW     = 9,
  parameter int unsigned MIN_DW = 5,
  parameter int unsigned OSR    = 16,
  parameter int unsigned NW     = $clog2(DW + 1)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          tick_i,
  input  logic [DW-1:0] data_i,
  input  logic          valid_i,
  output logic          ready_o,
  input  logic [NW-1:0] data_bits_i,
  input  logic          msb_first_i,
  input  logic [1:0]    parity_i,
  input  logic [1:0]    stop_sel_i,
  input  logic          cts_en_i,
  input  logic          cts_i,
  output logic          tx_o,
  output logic          tx_empty_o,
  output logic          tx_done_o
);
  logic          pend, load, start_ok;
  logic [DW-1:0] word;

  assign start_ok   = !cts_en_i || !cts_i;
  assign tx_empty_o = !pend;

  uart_tx_hold #(.DW(DW)) u_hold (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .valid_i (valid_i),
    .data_i  (data_i),
    .take_i  (load),
    .ready_o (ready_o),
    .pend_o  (pend),
    .word_o  (word)
  );

  uart_tx_shift #(.DW(DW), .MIN_DW(MIN_DW), .OSR(OSR), .NW(NW)) u_shift (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .tick_i      (tick_i),
    .pend_i      (pend),
    .start_ok_i  (start_ok),
    .word_i      (word),
    .len_i       (data_bits_i),
    .msb_first_i (msb_first_i),
    .par_mode_i  (parity_i),
    .stop_sel_i  (stop_sel_i),
    .load_o      (load),
    .tx_o        (tx_o),
    .done_o      (tx_done_o)
  );
endmodule

// File: tb/uart_frame_tx_test.sv
module uart_frame_tx_test;
  localparam int LOGN = 4096;

  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic       tick_i = 1'b0;
  logic [8:0] data_i = '0;
  logic       valid_i = 1'b0;
  logic       ready_o;
  logic [3:0] data_bits_i = 4'd8;
  logic       msb_first_i = 1'b0;
  logic [1:0] parity_i = 2'b00;
  logic [1:0] stop_sel_i = 2'b01;
  logic       cts_en_i = 1'b0;
  logic       cts_i = 1'b0;
  logic       tx_o, tx_empty_o, tx_done_o;

  int n_chk = 0, n_err = 0, cyc = 0, tdiv = 0;
  int log_n = 0, rd_ptr = 0;
  bit log_tx [LOGN];
  bit log_done [LOGN];
  bit log_empty [LOGN];

  uart_frame_tx uut (.*);

  always #4 clk_i = ~clk_i;

  always @(negedge clk_i) begin
    if (tick_i && log_n < LOGN) begin
      log_tx[log_n]    = tx_o;
      log_done[log_n]  = tx_done_o;
      log_empty[log_n] = tx_empty_o;
      log_n = log_n + 1;
    end
    tdiv   <= (tdiv == 2) ? 0 : tdiv + 1;
    tick_i <= (tdiv == 0);
  end

  always @(posedge clk_i) begin
    cyc <= cyc + 1;
    if (cyc > 190000) begin
      n_chk++; n_err++;
      $display("FAIL watchdog actual %0d expected <190000", cyc);
      $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
      $finish;
    end
  end

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s actual %0h expected %0h", tag, act, exp);
    end
  endtask

  function automatic bit exp_par(input logic [8:0] d, input int n, input int pm);
    bit p = 0;
    for (int k = 0; k < n; k++) p ^= d[k];
    return (pm == 2) ? ~p : p;
  endfunction

  task automatic set_cfg(input int n, input bit msb, input int pm, input int ss);
    @(negedge clk_i);
    data_bits_i = 4'(n); msb_first_i = msb; parity_i = 2'(pm); stop_sel_i = 2'(ss);
  endtask

  task automatic clr_log();
    @(posedge clk_i);
    log_n = 0; rd_ptr = 0;
  endtask

  task automatic wr(input logic [8:0] d);
    @(negedge clk_i);
    valid_i = 1'b1; data_i = d;
    while (!ready_o) @(negedge clk_i);
    @(negedge clk_i);
    valid_i = 1'b0;
  endtask

  task automatic wait_idle();
    while (!tx_empty_o) @(negedge clk_i);
    while (!tx_done_o) @(negedge clk_i);
    repeat (9) @(negedge clk_i);
  endtask

  task automatic check_frame(input logic [8:0] d, input int n, input bit msb,
                             input int pm, input int ss, input bit b2b);
    int i = rd_ptr, bad, base, slen, len, e;
    bit p_on = (pm == 1 || pm == 2);
    logic [8:0] got = '0, expv = '0;
    while (i < log_n && log_tx[i] != 1'b0) i++;
    if (i >= log_n) begin
      chk(0, "R2 no start bit", 1, 0);
      return;
    end
    bad = 0;
    for (int j = 0; j < 16; j++) if (log_tx[i+j] != 1'b0) bad++;
    chk(bad == 0, "R2 start width", bad, 0);
    bad = 0;
    for (int k = 0; k < n; k++) begin
      base = i + 16 * (k + 1);
      got[k]  = log_tx[base + 8];
      expv[k] = msb ? d[n-1-k] : d[k];
      for (int j = 0; j < 16; j++) if (log_tx[base+j] != got[k]) bad++;
    end
    chk(bad == 0, "R3 bit width", bad, 0);
    chk(got == expv, "R3/R4 data field", got, expv);
    if (p_on) begin
      base = i + 16 * (n + 1);
      bad = 0;
      for (int j = 0; j < 16; j++) if (log_tx[base+j] != exp_par(d, n, pm)) bad++;
      chk(bad == 0, "R5 parity bit", bad, 0);
    end
    slen = 8 * (ss + 1);
    base = i + 16 * (1 + n + int'(p_on));
    len  = 16 * (1 + n + int'(p_on)) + slen;
    e    = i + len;
    bad = 0;
    for (int j = 0; j < slen; j++) if (log_tx[base+j] != 1'b1) bad++;
    chk(bad == 0, "R6 stop level", bad, 0);
    if (b2b) chk(log_tx[e] == 1'b0, "R7 back-to-back start", log_tx[e], 0);
    else chk(log_done[e] && !log_done[e-1], "R6/R9 done at stop end",
             {log_done[e-1], log_done[e]}, 2'b01);
    rd_ptr = e;
  endtask

  task automatic run_one(input logic [8:0] d, input int n, input bit msb,
                         input int pm, input int ss);
    set_cfg(n, msb, pm, ss);
    clr_log();
    wr(d);
    wait_idle();
    check_frame(d, n, msb, pm, ss, 0);
  endtask

  initial begin
    int bad;
    logic [8:0] a, b, c;
    void'($urandom(32'h5a17));
    repeat (5) @(negedge clk_i);
    // R1 reset state
    chk(tx_o && tx_empty_o && tx_done_o && ready_o, "R1 reset state",
        {tx_o, tx_empty_o, tx_done_o, ready_o}, 4'hf);
    rst_ni = 1'b1;
    repeat (30) @(negedge clk_i);
    chk(tx_o, "R1 idle high", tx_o, 1);

    run_one(9'h050, 7, 0, 0, 1);   // R4 example
    run_one(9'h055, 8, 0, 1, 1);   // R5 even -> 0
    run_one(9'h055, 8, 0, 2, 1);   // R5 odd -> 1
    run_one(9'h1a5, 9, 1, 2, 3);   // R4 msb first, R6 two stops
    run_one(9'h013, 5, 1, 1, 0);   // R6 half stop
    run_one(9'h0c3, 6, 0, 3, 2);   // R5 code 11 is none, R6 1.5 stops

    for (int r = 0; r < 40; r++)
      run_one(9'($urandom), 5 + int'($urandom % 5), 1'($urandom), int'($urandom % 4),
              int'($urandom % 4));

    // R7 / R8 chained frames
    a = 9'($urandom); b = 9'($urandom); c = 9'($urandom);
    set_cfg(8, 0, 1, 0);
    clr_log();
    wr(a);
    while (!tx_empty_o) @(negedge clk_i);
    wr(b);
    chk(!ready_o && !tx_empty_o, "R8 full after accept", {ready_o, tx_empty_o}, 0);
    wr(c);
    wait_idle();
    check_frame(a, 8, 0, 1, 0, 1);
    chk(log_empty[rd_ptr] && !log_empty[rd_ptr-1], "R8 empty rises at load",
        {log_empty[rd_ptr-1], log_empty[rd_ptr]}, 2'b01);
    check_frame(b, 8, 0, 1, 0, 1);
    check_frame(c, 8, 0, 1, 0, 0);

    // R10 blocked start
    set_cfg(8, 0, 0, 1);
    cts_en_i = 1'b1; cts_i = 1'b1;
    clr_log();
    wr(9'h0a7);
    repeat (300) @(negedge clk_i);
    bad = 0;
    for (int j = 0; j < log_n; j++) if (!log_tx[j]) bad++;
    chk(bad == 0 && !tx_empty_o, "R10 cts holds frame", bad, 0);
    cts_i = 1'b0;
    wait_idle();
    check_frame(9'h0a7, 8, 0, 0, 1, 0);

    // R10 frame in progress completes, pending word waits
    clr_log();
    wr(9'h03c);
    while (!tx_empty_o) @(negedge clk_i);
    wr(9'h0e1);
    repeat (120) @(negedge clk_i);
    cts_i = 1'b1;
    while (!tx_done_o) @(negedge clk_i);
    repeat (60) @(negedge clk_i);
    check_frame(9'h03c, 8, 0, 0, 1, 0);
    bad = 0;
    for (int j = rd_ptr; j < log_n; j++) if (!log_tx[j]) bad++;
    chk(bad == 0 && !tx_empty_o, "R10 next frame held", bad, 0);
    cts_i = 1'b0;
    wait_idle();
    check_frame(9'h0e1, 8, 0, 0, 1, 0);

    // R10 gating disabled
    cts_en_i = 1'b0; cts_i = 1'b1;
    run_one(9'h099, 8, 0, 0, 1);
    cts_i = 1'b0;

    // R11 settings captured at frame start
    set_cfg(8, 0, 1, 1);
    clr_log();
    wr(9'h0b6);
    while (tx_o) @(negedge clk_i);
    data_bits_i = 4'd5; msb_first_i = 1'b1; parity_i = 2'b10; stop_sel_i = 2'b00;
    wait_idle();
    check_frame(9'h0b6, 8, 0, 1, 1, 0);

    $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
    $finish;
  end
endmodule